// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block follows one DMA data transfer between an IDE drive and a descriptor-driven DMA channel. The drive side arms it with a start request. The request carries the drive type (disk or optical), the command (read, write or trim), the starting block address, and either a sector count or a packet byte length. The DMA channel then presents memory chunks one at a time, each an address and a byte length. For every chunk that carries data, the sequencer issues one storage request with a byte offset into the medium, the memory address and the length, and waits for the storage side to answer.

Two counters track progress: a signed remaining byte count and an unsigned transferred byte index. The remaining count is signed so that a final chunk larger than the data left still reads as finished. The sequencer decides when the transfer is complete, reports success or failure, updates a drive status byte and a drive interrupt level, and gives the channel a one-cycle end-of-pass pulse. If the channel runs before the drive has armed a transfer, the sequencer gives a separate park pulse instead and issues nothing. An optical drive whose block address is all ones runs in non-block mode, which finishes after a single clamped memory copy.

Top module: `ide_dma_seq`

## Requirements
- R1: One cycle after `start_i`, `xfer_idx_o` is 0 and `status_o` is 0x80 with `drv_irq_o` low. `remain_o` is `start_pkt_len_i` for an optical drive, or `start_sect_i` times 512 for a disk. The transfer becomes active.
- R2: A chunk presented while no transfer is active gives a one-cycle `park_o` pulse and nothing else: no request, no done pulse, and both counters unchanged.
- R3: A chunk presented while active with `remain_o` zero or negative issues no request and completes successfully. One cycle later `cmpl_ok_o` and `done_o` pulse together, `status_o` becomes 0x50, `drv_irq_o` goes high, and the transfer goes inactive.
- R4: An active chunk of length zero gives only a `done_o` pulse and leaves both counters unchanged. No request ever carries a length of zero.
- R5: For a disk, the request offset is the block address times 512 plus the transferred index.
- R6: For an optical drive in block mode, the request offset is the block address times 2048 plus the transferred index.
- R7: When a request is issued, `remain_o` falls by the chunk length and `xfer_idx_o` rises by it, in the same cycle as `req_valid_o`. An overshoot shows as a negative remaining count.
- R8: In non-block mode (optical drive, block address all ones), the first data chunk issues a copy request with op 3, offset 0, to_dev low, and length equal to the smaller of the remaining count and the chunk length. `cmpl_ok_o` and `done_o` pulse in that same cycle, the counters are unchanged, and the transfer goes inactive.
- R9: The request op is taken from the command latched at start: 0 read, 1 write, 2 trim (a value of 3 is taken as read). An optical drive always uses read. `req_to_dev_o` is high for write and trim and low otherwise.
- R10: After a request, the storage answer `rsp_valid_i` with `rsp_err_i` high gives `cmpl_err_o` and `done_o`, sets `status_o` to 0x51 with `drv_irq_o` high, and ends the transfer. Without an error, it gives the R3 completion if the remaining count is at or below zero, and otherwise only `done_o`.
- R11: After reset, `status_o` is 0, `drv_irq_o` is low, both counters are 0, and no pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arm a new transfer (one-cycle pulse) |
| start_optical_i | input | 1 | Drive is optical (1) or disk (0) |
| start_cmd_i | input | 2 | Command: 0 read, 1 write, 2 trim |
| start_sect_i | input | SCNT_W | Disk sector count |
| start_pkt_len_i | input | LEN_W | Optical packet byte length |
| start_lba_i | input | LBA_W | Starting block address |
| chunk_valid_i | input | 1 | DMA channel presents a chunk |
| chunk_addr_i | input | ADDR_W | Chunk memory address |
| chunk_len_i | input | LEN_W | Chunk byte length |
| rsp_valid_i | input | 1 | Storage side answers the last request |
| rsp_err_i | input | 1 | Storage answer is an error |
| req_valid_o | output | 1 | Storage request pulse |
| req_op_o | output | 2 | Request op: 0 read, 1 write, 2 trim, 3 copy |
| req_to_dev_o | output | 1 | Data flows from memory toward the drive |
| req_offset_o | output | OFF_W | Byte offset on the medium |
| req_addr_o | output | ADDR_W | Memory address of the request |
| req_len_o | output | LEN_W | Request byte length |
| done_o | output | 1 | End-of-pass pulse to the DMA channel |
| park_o | output | 1 | Channel ran before arming; wait for restart |
| cmpl_ok_o | output | 1 | Successful completion pulse |
| cmpl_err_o | output | 1 | Error completion pulse |
| status_o | output | 8 | Drive status byte |
| drv_irq_o | output | 1 | Drive interrupt level |
| xfer_idx_o | output | LEN_W | Bytes transferred so far |
| remain_o | output | LEN_W | Signed bytes remaining |

## Verification
The bench builds the block with its default parameters: a 28-bit block address, 9-bit sector count, and 32-bit length and address fields. These widths make an all-ones optical address large enough to separate non-block mode from a real address. They also let a 1024-byte chunk against a 512-byte disk transfer drive the signed remaining count below zero. At these widths the 40-bit offset shows both the 512-byte and the 2048-byte scaling with the index added on top. The chosen sector counts and packet lengths reach multi-chunk transfers, an empty transfer that completes on the first chunk, and clamping in both directions for the copy.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_TRIM  = 2'd2,
    OP_COPY  = 2'd3
  } dma_op_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } seq_state_e;

  localparam int SECT_SHIFT = 9;
  localparam int BLK_SHIFT  = 11;

  localparam logic [7:0] STAT_BUSY = 8'h80;
  localparam logic [7:0] STAT_DONE = 8'h50;
  localparam logic [7:0] STAT_FAIL = 8'h51;

endpackage

// File: rtl/ide_dma_offset.sv
module ide_dma_offset
  import ide_dma_pkg::*;
#(
  parameter int LBA_W = 28,
  parameter int IDX_W = 32,
  parameter int OFF_W = 40
) (
  input  logic [LBA_W-1:0] lba_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             optical_i,
  output logic [OFF_W-1:0] off_o
);

  logic [OFF_W-1:0] base_disk;
  logic [OFF_W-1:0] base_opt;

  always_comb begin
    base_disk = OFF_W'({lba_i, {SECT_SHIFT{1'b0}}});
    base_opt  = OFF_W'({lba_i, {BLK_SHIFT{1'b0}}});
    off_o     = (optical_i ? base_opt : base_disk) + OFF_W'(idx_i);
  end

endmodule

// File: rtl/ide_dma_count.sv
module ide_dma_count #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [W-1:0]        load_val_i,
  input  logic                adv_i,
  input  logic [W-1:0]        adv_len_i,
  output logic signed [W-1:0] rem_o,
  output logic [W-1:0]        idx_o
);

  logic signed [W-1:0] rem_q, rem_d;
  logic [W-1:0]        idx_q, idx_d;
  logic                cnt_en;

  always_comb begin
    cnt_en = load_i | adv_i;
    rem_d  = rem_q;
    idx_d  = idx_q;
    if (load_i) begin
      rem_d = $signed(load_val_i);
      idx_d = '0;
    end else if (adv_i) begin
      rem_d = rem_q - $signed(adv_len_i);
      idx_d = idx_q + adv_len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (cnt_en) begin
      rem_q <= rem_d;
      idx_q <= idx_d;
    end
  end

  assign rem_o = rem_q;
  assign idx_o = idx_q;

endmodule

// File: rtl/ide_dma_ctrl.sv
module ide_dma_ctrl
  import ide_dma_pkg::*;
#(
  parameter int LBA_W  = 28,
  parameter int SCNT_W = 9,
  parameter int LEN_W  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    start_optical_i,
  input  logic [1:0]              start_cmd_i,
  input  logic [SCNT_W-1:0]       start_sect_i,
  input  logic [LEN_W-1:0]        start_pkt_len_i,
  input  logic [LBA_W-1:0]        start_lba_i,
  input  logic                    chunk_valid_i,
  input  logic [ADDR_W-1:0]       chunk_addr_i,
  input  logic [LEN_W-1:0]        chunk_len_i,
  input  logic                    rsp_valid_i,
  input  logic                    rsp_err_i,
  input  logic signed [LEN_W-1:0] rem_i,
  input  logic [OFF_W-1:0]        offset_i,
  output logic                    cnt_load_o,
  output logic [LEN_W-1:0]        cnt_load_val_o,
  output logic                    cnt_adv_o,
  output logic [LBA_W-1:0]        lba_o,
  output logic                    optical_o,
  output logic                    req_valid_o,
  output logic [1:0]              req_op_o,
  output logic                    req_to_dev_o,
  output logic [OFF_W-1:0]        req_offset_o,
  output logic [ADDR_W-1:0]       req_addr_o,
  output logic [LEN_W-1:0]        req_len_o,
  output logic                    done_o,
  output logic                    park_o,
  output logic                    ok_o,
  output logic                    err_o,
  output logic [7:0]              status_o,
  output logic                    irq_o
);

  seq_state_e        state_q, state_d;
  logic              active_q, active_d;
  logic              optical_q, optical_d;
  dma_op_e           op_q, op_d;
  logic [LBA_W-1:0]  lba_q, lba_d;
  logic [7:0]        status_q, status_d;
  logic              irq_q, irq_d;

  logic              rv_q, rv_d;
  dma_op_e           rop_q, rop_d;
  logic              rdev_q, rdev_d;
  logic [OFF_W-1:0]  roff_q, roff_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic [LEN_W-1:0]  rlen_q, rlen_d;
  logic              done_q, done_d;
  logic              park_q, park_d;
  logic              ok_q, ok_d;
  logic              err_q, err_d;

  logic              rem_le0;
  logic              nonblock;
  logic [LEN_W-1:0]  copy_len;
  logic              issue;
  logic              ctx_en;

  always_comb begin
    rem_le0  = rem_i[LEN_W-1] | (rem_i == '0);
    nonblock = optical_q & (&lba_q);
    copy_len = ($unsigned(rem_i) < chunk_len_i) ? $unsigned(rem_i) : chunk_len_i;
  end

  always_comb begin
    state_d  = state_q;
    active_d = active_q;
    optical_d = optical_q;
    op_d     = op_q;
    lba_d    = lba_q;
    status_d = status_q;
    irq_d    = irq_q;
    rv_d     = 1'b0;
    rop_d    = OP_READ;
    rdev_d   = 1'b0;
    roff_d   = '0;
    raddr_d  = '0;
    rlen_d   = '0;
    done_d   = 1'b0;
    park_d   = 1'b0;
    ok_d     = 1'b0;
    err_d    = 1'b0;
    issue    = 1'b0;
    ctx_en   = start_i;

    if (start_i) begin
      state_d   = SQ_IDLE;
      active_d  = 1'b1;
      optical_d = start_optical_i;
      lba_d     = start_lba_i;
      status_d  = STAT_BUSY;
      irq_d     = 1'b0;
      if (start_optical_i || start_cmd_i == 2'd3) op_d = OP_READ;
      else                                        op_d = dma_op_e'(start_cmd_i);
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (chunk_valid_i) begin
            if (!active_q) begin
              park_d = 1'b1;
            end else if (rem_le0) begin
              ok_d     = 1'b1;
              done_d   = 1'b1;
              active_d = 1'b0;
              status_d = STAT_DONE;
              irq_d    = 1'b1;
            end else if (chunk_len_i == '0) begin
              done_d = 1'b1;
            end else if (nonblock) begin
              rv_d     = 1'b1;
              rop_d    = OP_COPY;
              raddr_d  = chunk_addr_i;
              rlen_d   = copy_len;
              ok_d     = 1'b1;
              done_d   = 1'b1;
              active_d = 1'b0;
              status_d = STAT_DONE;
              irq_d    = 1'b1;
            end else begin
              issue   = 1'b1;
              rv_d    = 1'b1;
              rop_d   = op_q;
              rdev_d  = (op_q == OP_WRITE) || (op_q == OP_TRIM);
              roff_d  = offset_i;
              raddr_d = chunk_addr_i;
              rlen_d  = chunk_len_i;
              state_d = SQ_WAIT;
            end
          end
        end
        SQ_WAIT: begin
          if (rsp_valid_i) begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
            if (rsp_err_i) begin
              err_d    = 1'b1;
              active_d = 1'b0;
              status_d = STAT_FAIL;
              irq_d    = 1'b1;
            end else if (rem_le0) begin
              ok_d     = 1'b1;
              active_d = 1'b0;
              status_d = STAT_DONE;
              irq_d    = 1'b1;
            end
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      optical_q <= 1'b0;
      op_q      <= OP_READ;
      lba_q     <= '0;
    end else if (ctx_en) begin
      optical_q <= optical_d;
      op_q      <= op_d;
      lba_q     <= lba_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      active_q <= 1'b0;
      status_q <= 8'h00;
      irq_q    <= 1'b0;
      rv_q     <= 1'b0;
      rop_q    <= OP_READ;
      rdev_q   <= 1'b0;
      roff_q   <= '0;
      raddr_q  <= '0;
      rlen_q   <= '0;
      done_q   <= 1'b0;
      park_q   <= 1'b0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      active_q <= active_d;
      status_q <= status_d;
      irq_q    <= irq_d;
      rv_q     <= rv_d;
      rop_q    <= rop_d;
      rdev_q   <= rdev_d;
      roff_q   <= roff_d;
      raddr_q  <= raddr_d;
      rlen_q   <= rlen_d;
      done_q   <= done_d;
      park_q   <= park_d;
      ok_q     <= ok_d;
      err_q    <= err_d;
    end
  end

  assign cnt_load_o     = start_i;
  assign cnt_load_val_o = start_optical_i ? start_pkt_len_i
                                          : LEN_W'({start_sect_i, {SECT_SHIFT{1'b0}}});
  assign cnt_adv_o      = issue;
  assign lba_o          = lba_q;
  assign optical_o      = optical_q;
  assign req_valid_o    = rv_q;
  assign req_op_o       = rop_q;
  assign req_to_dev_o   = rdev_q;
  assign req_offset_o   = roff_q;
  assign req_addr_o     = raddr_q;
  assign req_len_o      = rlen_q;
  assign done_o         = done_q;
  assign park_o         = park_q;
  assign ok_o           = ok_q;
  assign err_o          = err_q;
  assign status_o       = status_q;
  assign irq_o          = irq_q;

endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq
  import ide_dma_pkg::*;
#(
  parameter int LBA_W  = 28,
  parameter int SCNT_W = 9,
  parameter int LEN_W  = 32,
  parameter int ADDR_W = 32,
  localparam int OFF_W = ((LBA_W + BLK_SHIFT > LEN_W) ? LBA_W + BLK_SHIFT : LEN_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              start_optical_i,
  input  logic [1:0]        start_cmd_i,
  input  logic [SCNT_W-1:0] start_sect_i,
  input  logic [LEN_W-1:0]  start_pkt_len_i,
  input  logic [LBA_W-1:0]  start_lba_i,
  input  logic              chunk_valid_i,
  input  logic [ADDR_W-1:0] chunk_addr_i,
  input  logic [LEN_W-1:0]  chunk_len_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  output logic              req_valid_o,
  output logic [1:0]        req_op_o,
  output logic              req_to_dev_o,
  output logic [OFF_W-1:0]  req_offset_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              done_o,
  output logic              park_o,
  output logic              cmpl_ok_o,
  output logic              cmpl_err_o,
  output logic [7:0]        status_o,
  output logic              drv_irq_o,
  output logic [LEN_W-1:0]  xfer_idx_o,
  output logic [LEN_W-1:0]  remain_o
);

  logic                    cnt_load;
  logic [LEN_W-1:0]        cnt_load_val;
  logic                    cnt_adv;
  logic signed [LEN_W-1:0] rem;
  logic [LEN_W-1:0]        idx;
  logic [LBA_W-1:0]        lba;
  logic                    optical;
  logic [OFF_W-1:0]        offset;

  ide_dma_count #(.W(LEN_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .adv_i      (cnt_adv),
    .adv_len_i  (chunk_len_i),
    .rem_o      (rem),
    .idx_o      (idx)
  );

  ide_dma_offset #(.LBA_W(LBA_W), .IDX_W(LEN_W), .OFF_W(OFF_W)) u_offset (
    .lba_i     (lba),
    .idx_i     (idx),
    .optical_i (optical),
    .off_o     (offset)
  );

  ide_dma_ctrl #(
    .LBA_W(LBA_W), .SCNT_W(SCNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .start_optical_i (start_optical_i),
    .start_cmd_i     (start_cmd_i),
    .start_sect_i    (start_sect_i),
    .start_pkt_len_i (start_pkt_len_i),
    .start_lba_i     (start_lba_i),
    .chunk_valid_i   (chunk_valid_i),
    .chunk_addr_i    (chunk_addr_i),
    .chunk_len_i     (chunk_len_i),
    .rsp_valid_i     (rsp_valid_i),
    .rsp_err_i       (rsp_err_i),
    .rem_i           (rem),
    .offset_i        (offset),
    .cnt_load_o      (cnt_load),
    .cnt_load_val_o  (cnt_load_val),
    .cnt_adv_o       (cnt_adv),
    .lba_o           (lba),
    .optical_o       (optical),
    .req_valid_o     (req_valid_o),
    .req_op_o        (req_op_o),
    .req_to_dev_o    (req_to_dev_o),
    .req_offset_o    (req_offset_o),
    .req_addr_o      (req_addr_o),
    .req_len_o       (req_len_o),
    .done_o          (done_o),
    .park_o          (park_o),
    .ok_o            (cmpl_ok_o),
    .err_o           (cmpl_err_o),
    .status_o        (status_o),
    .irq_o           (drv_irq_o)
  );

  assign xfer_idx_o = idx;
  assign remain_o   = rem;

endmodule

// File: rtl/ide_dma_seq_chk.sv
module ide_dma_seq_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             req_valid_o,
  input logic [1:0]       req_op_o,
  input logic             req_to_dev_o,
  input logic [LEN_W-1:0] req_len_o,
  input logic             done_o,
  input logic             park_o,
  input logic             cmpl_ok_o,
  input logic             cmpl_err_o,
  input logic [7:0]       status_o,
  input logic             drv_irq_o,
  input logic [LEN_W-1:0] xfer_idx_o,
  input logic [LEN_W-1:0] remain_o
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_i && rst_n) |-> (xfer_idx_o == '0) && (status_o == 8'h80) && !drv_irq_o); // R1

  AST_PARK_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    park_o |-> !req_valid_o && !done_o && !cmpl_ok_o && !cmpl_err_o); // R2

  AST_OK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_ok_o |-> drv_irq_o && (status_o == 8'h50) && done_o); // R3

  AST_NO_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_len_o != '0)); // R4

  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_op_o != 2'd3) |->
      (xfer_idx_o == $past(xfer_idx_o) + req_len_o) &&
      (remain_o == $past(remain_o) - req_len_o)); // R7

  AST_COPY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_op_o == 2'd3) |-> done_o && cmpl_ok_o && !req_to_dev_o); // R8

  AST_TRIM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_op_o == 2'd2) |-> req_to_dev_o); // R9

  AST_ERR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_err_o |-> done_o && !cmpl_ok_o && drv_irq_o && (status_o == 8'h51)); // R10

endmodule

bind ide_dma_seq ide_dma_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .req_valid_o  (req_valid_o),
  .req_op_o     (req_op_o),
  .req_to_dev_o (req_to_dev_o),
  .req_len_o    (req_len_o),
  .done_o       (done_o),
  .park_o       (park_o),
  .cmpl_ok_o    (cmpl_ok_o),
  .cmpl_err_o   (cmpl_err_o),
  .status_o     (status_o),
  .drv_irq_o    (drv_irq_o),
  .xfer_idx_o   (xfer_idx_o),
  .remain_o     (remain_o)
);

// File: tb/ide_dma_seq_test.sv
module ide_dma_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [27:0] LBA_ONES = 28'hFFFFFFF;

  typedef struct packed {
    logic        req;
    logic [1:0]  op;
    logic        to_dev;
    logic [39:0] off;
    logic [31:0] addr;
    logic [31:0] len;
    logic        done;
    logic        park;
    logic        ok;
    logic        err;
  } ev_t;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        start_optical_i;
  logic [1:0]  start_cmd_i;
  logic [8:0]  start_sect_i;
  logic [31:0] start_pkt_len_i;
  logic [27:0] start_lba_i;
  logic        chunk_valid_i;
  logic [31:0] chunk_addr_i;
  logic [31:0] chunk_len_i;
  logic        rsp_valid_i;
  logic        rsp_err_i;
  logic        req_valid_o;
  logic [1:0]  req_op_o;
  logic        req_to_dev_o;
  logic [39:0] req_offset_o;
  logic [31:0] req_addr_o;
  logic [31:0] req_len_o;
  logic        done_o;
  logic        park_o;
  logic        cmpl_ok_o;
  logic        cmpl_err_o;
  logic [7:0]  status_o;
  logic        drv_irq_o;
  logic [31:0] xfer_idx_o;
  logic [31:0] remain_o;

  ide_dma_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_optical_i(start_optical_i),
    .start_cmd_i(start_cmd_i), .start_sect_i(start_sect_i), .start_pkt_len_i(start_pkt_len_i),
    .start_lba_i(start_lba_i), .chunk_valid_i(chunk_valid_i), .chunk_addr_i(chunk_addr_i),
    .chunk_len_i(chunk_len_i), .rsp_valid_i(rsp_valid_i), .rsp_err_i(rsp_err_i),
    .req_valid_o(req_valid_o), .req_op_o(req_op_o), .req_to_dev_o(req_to_dev_o),
    .req_offset_o(req_offset_o), .req_addr_o(req_addr_o), .req_len_o(req_len_o),
    .done_o(done_o), .park_o(park_o), .cmpl_ok_o(cmpl_ok_o), .cmpl_err_o(cmpl_err_o),
    .status_o(status_o), .drv_irq_o(drv_irq_o), .xfer_idx_o(xfer_idx_o), .remain_o(remain_o)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  ev_t   exp_q[$];
  string tag_q[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic ev_t ev_req(logic [1:0] op, logic to_dev, logic [39:0] off,
                                 logic [31:0] addr, logic [31:0] len, logic ok, logic done);
    ev_t e = '0;
    e.req = 1'b1; e.op = op; e.to_dev = to_dev; e.off = off;
    e.addr = addr; e.len = len; e.ok = ok; e.done = done;
    return e;
  endfunction

  function automatic ev_t ev_flag(logic done, logic park, logic ok, logic err);
    ev_t e = '0;
    e.done = done; e.park = park; e.ok = ok; e.err = err;
    return e;
  endfunction

  task automatic expect_ev(ev_t e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic check_val(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every output event
  always @(negedge clk) begin
    if (rst_n && (req_valid_o || done_o || park_o || cmpl_ok_o || cmpl_err_o)) begin
      ev_t obs;
      obs = '0;
      obs.req = req_valid_o;
      if (req_valid_o) begin
        obs.op = req_op_o; obs.to_dev = req_to_dev_o; obs.off = req_offset_o;
        obs.addr = req_addr_o; obs.len = req_len_o;
      end
      obs.done = done_o; obs.park = park_o; obs.ok = cmpl_ok_o; obs.err = cmpl_err_o;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected event: actual=%0h expected=none", obs);
      end else begin
        ev_t   e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (obs !== e) begin
          errors++;
          $display("FAIL %s event: actual=%0h expected=%0h", t, obs, e);
        end
      end
    end
  end

  task automatic start_xfer(logic opt, logic [1:0] cmd, logic [8:0] sect,
                            logic [31:0] pkt, logic [27:0] lba);
    @(negedge clk);
    start_i = 1'b1; start_optical_i = opt; start_cmd_i = cmd;
    start_sect_i = sect; start_pkt_len_i = pkt; start_lba_i = lba;
    @(negedge clk);
    start_i = 1'b0;
    check_val("R1", "index", 64'(xfer_idx_o), 64'd0);
    check_val("R1", "remain", 64'(remain_o), opt ? 64'(pkt) : 64'(32'(sect) * 32'd512));
    check_val("R1", "status", 64'(status_o), 64'h80);
    check_val("R1", "irq", 64'(drv_irq_o), 64'd0);
  endtask

  task automatic send_chunk(logic [31:0] addr, logic [31:0] len);
    @(negedge clk);
    chunk_valid_i = 1'b1; chunk_addr_i = addr; chunk_len_i = len;
    @(negedge clk);
    chunk_valid_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_rsp(logic err);
    @(negedge clk);
    rsp_valid_i = 1'b1; rsp_err_i = err;
    @(negedge clk);
    rsp_valid_i = 1'b0; rsp_err_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_optical_i = 1'b0; start_cmd_i = 2'd0;
    start_sect_i = '0; start_pkt_len_i = '0; start_lba_i = '0;
    chunk_valid_i = 1'b0; chunk_addr_i = '0; chunk_len_i = '0;
    rsp_valid_i = 1'b0; rsp_err_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check_val("R11", "status", 64'(status_o), 64'h00);
    check_val("R11", "irq", 64'(drv_irq_o), 64'd0);
    check_val("R11", "remain", 64'(remain_o), 64'd0);
    check_val("R11", "index", 64'(xfer_idx_o), 64'd0);
    check_val("R11", "pulses", 64'({req_valid_o, done_o, park_o, cmpl_ok_o, cmpl_err_o}), 64'd0);

    // R2 channel runs before arming
    expect_ev(ev_flag(1'b0, 1'b1, 1'b0, 1'b0), "R2");
    send_chunk(32'h100, 32'd64);
    check_val("R2", "index", 64'(xfer_idx_o), 64'd0);

    // disk read, two sectors at block 5
    start_xfer(1'b0, 2'd0, 9'd2, 32'd0, 28'd5);
    expect_ev(ev_req(2'd0, 1'b0, 40'(5 * 512), 32'h1000, 32'd512, 1'b0, 1'b0), "R5");
    send_chunk(32'h1000, 32'd512);
    check_val("R7", "remain", 64'(remain_o), 64'd512);
    check_val("R7", "index", 64'(xfer_idx_o), 64'd512);
    expect_ev(ev_flag(1'b1, 1'b0, 1'b0, 1'b0), "R10");
    send_rsp(1'b0);
    expect_ev(ev_flag(1'b1, 1'b0, 1'b0, 1'b0), "R4");
    send_chunk(32'h3000, 32'd0);
    check_val("R4", "remain", 64'(remain_o), 64'd512);
    check_val("R4", "index", 64'(xfer_idx_o), 64'd512);
    expect_ev(ev_req(2'd0, 1'b0, 40'(5 * 512 + 512), 32'h2000, 32'd512, 1'b0, 1'b0), "R5");
    send_chunk(32'h2000, 32'd512);
    expect_ev(ev_flag(1'b1, 1'b0, 1'b1, 1'b0), "R10");
    send_rsp(1'b0);
    check_val("R3", "status", 64'(status_o), 64'h50);
    check_val("R3", "irq", 64'(drv_irq_o), 64'd1);
    expect_ev(ev_flag(1'b0, 1'b1, 1'b0, 1'b0), "R2");
    send_chunk(32'h4000, 32'd512);
    check_val("R2", "index", 64'(xfer_idx_o), 64'd1024);

    // disk write with overshoot
    start_xfer(1'b0, 2'd1, 9'd1, 32'd0, 28'd0);
    expect_ev(ev_req(2'd1, 1'b1, 40'd0, 32'h5000, 32'd1024, 1'b0, 1'b0), "R9");
    send_chunk(32'h5000, 32'd1024);
    check_val("R7", "remain", 64'(remain_o), 64'(32'hFFFF_FE00));
    expect_ev(ev_flag(1'b1, 1'b0, 1'b1, 1'b0), "R10");
    send_rsp(1'b0);

    // disk trim with a storage error
    start_xfer(1'b0, 2'd2, 9'd1, 32'd0, 28'd1);
    expect_ev(ev_req(2'd2, 1'b1, 40'd512, 32'h6000, 32'd512, 1'b0, 1'b0), "R9");
    send_chunk(32'h6000, 32'd512);
    expect_ev(ev_flag(1'b1, 1'b0, 1'b0, 1'b1), "R10");
    send_rsp(1'b1);
    check_val("R10", "status", 64'(status_o), 64'h51);
    check_val("R10", "irq", 64'(drv_irq_o), 64'd1);
    expect_ev(ev_flag(1'b0, 1'b1, 1'b0, 1'b0), "R10");
    send_chunk(32'h6200, 32'd512);

    // optical block mode, command write forced to read
    start_xfer(1'b1, 2'd1, 9'd0, 32'd4096, 28'd3);
    expect_ev(ev_req(2'd0, 1'b0, 40'(3 * 2048), 32'h7000, 32'd2048, 1'b0, 1'b0), "R6");
    send_chunk(32'h7000, 32'd2048);
    expect_ev(ev_flag(1'b1, 1'b0, 1'b0, 1'b0), "R10");
    send_rsp(1'b0);
    expect_ev(ev_req(2'd0, 1'b0, 40'(3 * 2048 + 2048), 32'h7800, 32'd2048, 1'b0, 1'b0), "R6");
    send_chunk(32'h7800, 32'd2048);
    expect_ev(ev_flag(1'b1, 1'b0, 1'b1, 1'b0), "R10");
    send_rsp(1'b0);

    // non-block copy, clamped to remaining
    start_xfer(1'b1, 2'd0, 9'd0, 32'd100, LBA_ONES);
    expect_ev(ev_req(2'd3, 1'b0, 40'd0, 32'h8000, 32'd100, 1'b1, 1'b1), "R8");
    send_chunk(32'h8000, 32'd4096);
    check_val("R8", "remain", 64'(remain_o), 64'd100);
    check_val("R8", "index", 64'(xfer_idx_o), 64'd0);
    expect_ev(ev_flag(1'b0, 1'b1, 1'b0, 1'b0), "R8");
    send_chunk(32'h8100, 32'd64);

    // non-block copy, clamped to chunk
    start_xfer(1'b1, 2'd0, 9'd0, 32'd300, LBA_ONES);
    expect_ev(ev_req(2'd3, 1'b0, 40'd0, 32'h9000, 32'd64, 1'b1, 1'b1), "R8");
    send_chunk(32'h9000, 32'd64);

    // empty disk transfer completes on first chunk
    start_xfer(1'b0, 2'd0, 9'd0, 32'd0, 28'd9);
    expect_ev(ev_flag(1'b1, 1'b0, 1'b1, 1'b0), "R3");
    send_chunk(32'hA000, 32'd512);
    check_val("R3", "status", 64'(status_o), 64'h50);

    repeat (4) @(negedge clk);
    check_val("R10", "scoreboard drained", 64'(exp_q.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule